// File: doc/BRIEF.md
# Register List Transfer Sequencer

This block orders the register transfers of a multi-register move. A request carries a 16-bit register mask, a direction and a transfer size. For each set mask bit the block presents one register selection, together with a running byte offset, on a valid/ready output stream. The memory side takes each selection with a handshake. When the list is exhausted, a one-cycle done flag marks the end. The block does not compute the effective address and does not perform the memory access. It only decides which register goes next and how far into the block that register lies.

The mask is consumed from bit 0 upwards. Clear bits cost no cycles, so every output beat is a real transfer. The direction input reverses the mapping from mask bits to registers. In the normal direction, low mask bits name data registers 0 to 7. In the reversed direction, low mask bits name address register 7 down to 0. Only long-word transfers exist. A request of any other size is refused with a one-cycle error flag.

Back-pressure rules: a beat moves on a clock edge where `xfer_valid` and `xfer_ready` are both high. While `xfer_valid` is high and `xfer_ready` is low, the register code and offset hold steady, and valid stays high until the beat is taken. `xfer_ready` may be high at any time; it has no effect when no beat is offered. The start request is a plain pulse with no handshake. It is taken only when no sequence is running.

Top module: `reglist_seq`

## Requirements
- R1: After reset, `xfer_valid`, `done` and `size_err` are all low.
- R2: In the normal direction (`req_dir`=0), mask bit i is output as register code i. Code bit 3 = 0 means data register [2:0]; code bit 3 = 1 means address register [2:0].
- R3: In the reversed direction (`req_dir`=1), mask bit i is output as register code 15-i, so bit 0 names address register 7 and bit 15 names data register 0.
- R4: Transfers are issued in ascending mask bit order, one per accepted handshake. Clear bits are skipped with no idle beat, and exactly as many transfers occur as the mask has set bits.
- R5: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_reg` and `xfer_offset` do not change at the next edge.
- R6: `xfer_offset` is 0 on the first transfer of a sequence and grows by 4 with each following transfer.
- R7: `done` is high for exactly one cycle. That cycle follows the handshake of the last transfer, or follows the start cycle when the mask is zero. `done` is never high together with `xfer_valid`.
- R8: A start whose `req_size` is not 2'b10 (long; 2'b00 byte, 2'b01 word, 2'b11 reserved) raises `size_err` for the next cycle only. It issues no transfer and no `done`.
- R9: A start pulse that arrives while a sequence is running is ignored. The running sequence completes with its own mask, direction and offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse, sampled when idle |
| req_dir | input | 1 | 0 normal mapping, 1 reversed mapping |
| req_size | input | 2 | Transfer size; only 2'b10 (long) accepted |
| req_mask | input | 16 | Register mask, bit 0 consumed first |
| xfer_valid | output | 1 | A register transfer is offered |
| xfer_ready | input | 1 | Memory side accepts the offered transfer |
| xfer_reg | output | 4 | Register code: bit 3 address/data, [2:0] number |
| xfer_offset | output | 6 | Byte offset of this transfer in the block |
| done | output | 1 | One-cycle end-of-sequence flag |
| size_err | output | 1 | One-cycle flag for a refused size |

## Verification
The bench builds the block with its default mask width of 16, so the offset field is 6 bits wide. This reaches the full 16-transfer list, which puts the largest offset, 60, onto the output. It also reaches the mask bits 7/8, where the code crosses between the data and address banks in both directions. With this width, sparse, full, single-ended and zero masks can be walked under stalling and non-stalling ready patterns, and the reversed mapping can be compared bit for bit with the normal one.

// File: rtl/reglist_seq_pkg.sv
package reglist_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned LONG_BYTES = 4;

endpackage

// File: rtl/rls_pick.sv
module rls_pick #(
  parameter int unsigned MASK_W = 16,
  localparam int unsigned IDX_W = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] mask,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);

  // lowest set bit: a thermometer of "already found below" per position
  logic [MASK_W:0] below;
  logic [MASK_W-1:0] hit;

  assign below[0] = 1'b0;

  for (genvar g = 0; g < MASK_W; g++) begin : g_scan
    assign hit[g]       = mask[g] & ~below[g];
    assign below[g + 1] = below[g] | mask[g];
  end

  assign any = below[MASK_W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  // R4: at most one position is chosen
  onehot_hit_chk: assert property (@(hit) $onehot0(hit))
    else $error("rls_pick: several bits chosen");

endmodule

// File: rtl/rls_map.sv
module rls_map #(
  parameter int unsigned MASK_W = 16,
  localparam int unsigned IDX_W = $clog2(MASK_W)
) (
  input  logic             rev,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] code
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(MASK_W - 1);

  // reversing the list mirrors the index across the whole register file
  always_comb begin
    if (rev) code = TOP - idx;
    else     code = idx;
  end

endmodule

// File: rtl/rls_ctrl.sv
module rls_ctrl
  import reglist_seq_pkg::*;
#(
  parameter int unsigned MASK_W = 16,
  localparam int unsigned IDX_W = $clog2(MASK_W),
  localparam int unsigned OFS_W = $clog2(MASK_W * LONG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_dir,
  input  logic [1:0]        req_size,
  input  logic [MASK_W-1:0] req_mask,
  input  logic              pick_any,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic              xfer_ready,
  output logic [MASK_W-1:0] rem_mask,
  output logic              dir_q,
  output logic              xfer_valid,
  output logic [OFS_W-1:0]  xfer_offset,
  output logic              done,
  output logic              size_err
);

  seq_state_e state_q;
  logic       take;
  logic       hs;
  logic       size_ok;
  logic [MASK_W-1:0] after_hs;

  assign size_ok    = (xfer_size_e'(req_size) == SZ_LONG);
  assign take       = req_start && (state_q == ST_IDLE);
  assign xfer_valid = (state_q == ST_RUN) && pick_any;
  assign hs         = xfer_valid && xfer_ready;

  always_comb begin
    after_hs = rem_mask;
    after_hs[pick_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rem_mask    <= '0;
      dir_q       <= 1'b0;
      xfer_offset <= '0;
      done        <= 1'b0;
      size_err    <= 1'b0;
    end else begin
      done     <= 1'b0;
      size_err <= 1'b0;
      if (take) begin
        if (!size_ok) begin
          size_err <= 1'b1;
        end else if (req_mask == '0) begin
          done <= 1'b1;
        end else begin
          state_q     <= ST_RUN;
          rem_mask    <= req_mask;
          dir_q       <= req_dir;
          xfer_offset <= '0;
        end
      end else if (hs) begin
        rem_mask    <= after_hs;
        xfer_offset <= xfer_offset + OFS_W'(LONG_BYTES);
        if (after_hs == '0) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_offset) && $stable(pick_idx)))
    else $error("stalled beat changed");

  // R6
  offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (after_hs != '0)) |=> (xfer_offset == $past(xfer_offset) + OFS_W'(LONG_BYTES)))
    else $error("offset step wrong");

  // R7
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!xfer_valid && !size_err))
    else $error("done overlaps a beat or error");

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (!xfer_valid && !done))
    else $error("size error with activity");

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && req_start && !xfer_ready) |=> ($stable(rem_mask) && $stable(dir_q)))
    else $error("start accepted while busy");

endmodule

// File: rtl/reglist_seq.sv
module reglist_seq
  import reglist_seq_pkg::*;
#(
  parameter int unsigned MASK_W = 16,
  localparam int unsigned IDX_W = $clog2(MASK_W),
  localparam int unsigned OFS_W = $clog2(MASK_W * LONG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_dir,
  input  logic [1:0]        req_size,
  input  logic [MASK_W-1:0] req_mask,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [IDX_W-1:0]  xfer_reg,
  output logic [OFS_W-1:0]  xfer_offset,
  output logic              done,
  output logic              size_err
);

  logic [MASK_W-1:0] rem_mask;
  logic              dir_q;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;

  rls_pick #(.MASK_W(MASK_W)) u_pick (
    .mask (rem_mask),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  rls_map #(.MASK_W(MASK_W)) u_map (
    .rev  (dir_q),
    .idx  (pick_idx),
    .code (xfer_reg)
  );

  rls_ctrl #(.MASK_W(MASK_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .req_dir     (req_dir),
    .req_size    (req_size),
    .req_mask    (req_mask),
    .pick_any    (pick_any),
    .pick_idx    (pick_idx),
    .xfer_ready  (xfer_ready),
    .rem_mask    (rem_mask),
    .dir_q       (dir_q),
    .xfer_valid  (xfer_valid),
    .xfer_offset (xfer_offset),
    .done        (done),
    .size_err    (size_err)
  );

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> $stable(xfer_reg))
    else $error("register code moved under stall");

endmodule

// File: tb/sim_reglist_seq.sv
module sim_reglist_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_dir = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [15:0] req_mask = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [5:0]  xfer_offset;
  logic        done;
  logic        size_err;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  reglist_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_dir(req_dir),
    .req_size(req_size), .req_mask(req_mask), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_reg(xfer_reg), .xfer_offset(xfer_offset),
    .done(done), .size_err(size_err)
  );

  typedef struct packed {
    logic [15:0] mask;
    logic        dir;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 1'b0, 1'b0},
    '{16'h8000, 1'b0, 1'b1},
    '{16'hFFFF, 1'b0, 1'b1},
    '{16'hFFFF, 1'b1, 1'b0},
    '{16'h00FF, 1'b1, 1'b1},
    '{16'hA5C3, 1'b0, 1'b1},
    '{16'h0101, 1'b1, 1'b0},
    '{16'h8001, 1'b1, 1'b1},
    '{16'h0180, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected code of the k-th set bit, from R2/R3
  function automatic int exp_code(input logic [15:0] m, input logic d, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return d ? (15 - i) : i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic run_seq(input logic [15:0] m, input logic d, input logic stall,
                         input bit poke_busy);
    int got = 0;
    int cyc = 0;
    int want = $countones(m);
    bit fin = 0;
    @(negedge clk);
    req_start = 1'b1; req_mask = m; req_dir = d; req_size = 2'b10;
    @(negedge clk);
    req_start = 1'b0;
    while (!fin && cyc < 200) begin
      if (done) begin
        fin = 1;
        // R4 transfer count, R7 done follows last beat
        chk(got == want, "R4 count", got, want);
        chk(!xfer_valid, "R7 done alone", xfer_valid, 0);
      end else begin
        if (xfer_valid) begin
          int ec = exp_code(m, d, got);
          chk(xfer_reg == ec[3:0], d ? "R3 code" : "R2 code", xfer_reg, ec);
          chk(xfer_offset == 6'(got * 4), "R6 offset", xfer_offset, got * 4);
        end else begin
          chk(1'b0, "R4 gap beat", 0, 1);
        end
        xfer_ready = !(stall && (cyc % 3 == 1));
        if (poke_busy && cyc == 1) begin
          req_start = 1'b1; req_mask = 16'h8000; req_dir = ~d;
        end else begin
          req_start = 1'b0;
        end
        if (xfer_valid && xfer_ready) got++;
        @(negedge clk);
        cyc++;
      end
    end
    req_start = 1'b0;
    xfer_ready = 1'b0;
    if (!fin) chk(1'b0, "R7 no done", 0, 1);
    @(negedge clk);
    chk(!done, "R7 one cycle", done, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!xfer_valid && !done && !size_err, "R1 reset", {xfer_valid, done, size_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xfer_valid && !done && !size_err, "R1 after release", {xfer_valid, done, size_err}, 0);

    for (int v = 0; v < NV; v++) run_seq(VECS[v].mask, VECS[v].dir, VECS[v].stall, 1'b0);

    // R7 zero mask: done in the cycle after start
    @(negedge clk);
    req_start = 1'b1; req_mask = 16'h0000; req_size = 2'b10;
    @(negedge clk);
    req_start = 1'b0;
    chk(done && !xfer_valid, "R7 zero mask", {done, xfer_valid}, 2);
    @(negedge clk);
    chk(!done, "R7 zero mask pulse", done, 0);

    // R8 refused sizes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      @(negedge clk);
      req_start = 1'b1; req_mask = 16'hFFFF; req_size = 2'(s);
      @(negedge clk);
      req_start = 1'b0; req_size = 2'b10;
      chk(size_err && !xfer_valid && !done, "R8 error", {size_err, xfer_valid, done}, 4);
      @(negedge clk);
      chk(!size_err && !xfer_valid && !done, "R8 quiet", {size_err, xfer_valid, done}, 0);
    end

    // R5 stall hold
    @(negedge clk);
    req_start = 1'b1; req_mask = 16'h0006; req_dir = 1'b0;
    @(negedge clk);
    req_start = 1'b0;
    xfer_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(xfer_valid && xfer_reg == 4'd1 && xfer_offset == 6'd0, "R5 hold",
          {xfer_valid, xfer_reg, xfer_offset}, {1'b1, 4'd1, 6'd0});
    end
    xfer_ready = 1'b1;
    @(negedge clk);
    chk(xfer_valid && xfer_reg == 4'd2 && xfer_offset == 6'd4, "R5 resume",
        {xfer_valid, xfer_reg, xfer_offset}, {1'b1, 4'd2, 6'd4});
    @(negedge clk);
    chk(done, "R7 after stall", done, 1);
    xfer_ready = 1'b0;
    @(negedge clk);

    // R9 start while busy is ignored
    run_seq(16'h0003, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk(!xfer_valid, "R9 no late start", xfer_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule